// File: doc/BRIEF.md
# Delay-Balanced Multiply-Accumulate Recurrence

This block evaluates a running multiply-add recurrence at one input pair per clock. Each accepted sample pair (a, b) produces a new accumulator value equal to an earlier accumulator value times a, plus b. The result is presented on the output with a valid strobe. There is no back-pressure: the producer may assert `in_valid` on any cycle, including every cycle.

The multiplier has two pipeline stages. A plain `acc = acc * a + b` loop could therefore accept a sample only every second cycle. To sustain one sample per cycle, the feedback operand is taken from a delay line whose depth equals the multiplier latency divided by the initiation interval, which is two here. Sample n therefore uses the result of sample n-2.

The output stream is two interleaved recurrences: even-numbered samples form one chain and odd-numbered samples form the other. A short forwarding network chooses the feedback operand. Depending on how many samples are still inside the multiplier, it takes either the adder output or an entry of the delay line. The result for sample n therefore depends only on the sequence of accepted samples, not on how many idle cycles lie between them.

Top module: `mac_interleave_rec`

## Requirements
- R1: For the n-th accepted sample (counting from 0 after reset), `out_acc` equals acc[n-2] * a[n] + b[n]. The value acc[k] is the k-th result, and acc[-1] = acc[-2] = 0.
- R2: A new sample is accepted on every cycle that has `in_valid` high. Each accepted sample yields exactly one result, and the results appear in acceptance order.
- R3: `out_valid` is high in the cycle following the third rising edge counted from, and including, the edge at which the sample's `in_valid` was captured. It is low in every other cycle.
- R4: Reset clears the accumulator and both delay-line entries to zero, so the first two results after reset equal their b inputs.
- R5: Cycles with `in_valid` low consume nothing. The `in_a` and `in_b` values on those cycles have no effect, and gaps of any length between samples leave the results unchanged.
- R6: While `out_valid` is low, `out_acc` keeps the last result it presented (zero after reset).
- R7: In the cycle after the last reset edge, `out_valid` is low and `out_acc` is zero.
- R8: Operands and results are 32-bit two's-complement values, and the product and the sum wrap modulo 2^32.
- R9: A reset asserted in the middle of a stream discards every sample still in flight, so no result comes out for them. The recurrence then restarts from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample pair present this cycle |
| in_a | input | W (32) | Signed multiplier operand |
| in_b | input | W (32) | Signed addend |
| out_valid | output | 1 | Result present this cycle |
| out_acc | output | W (32) | Signed updated accumulator |

## Verification
The bound checker checks four things on every cycle:
- the fixed three-edge latency from `in_valid` to `out_valid`;
- the recurrence, checked against the two most recent presented results and the delayed port operands;
- that the output holds while idle;
- the cleared output after reset.

Only the bench scenarios can show the following:
- exhaustive small-operand sweeps issued back to back;
- the same stream with irregular gaps and junk operands on idle cycles;
- wrap-around with extreme 32-bit values;
- the loss of in-flight samples on a reset in mid-stream.

All of these are compared with a software model that uses the two-deep delayed feedback.

// File: rtl/mac_rec_pkg.sv
package mac_rec_pkg;
    // latency of the pipelined multiplier, in clock cycles
    localparam int MUL_LAT  = 2;
    // target initiation interval of the recurrence
    localparam int INIT_INT = 1;
    // feedback delay elements needed to balance the loop
    localparam int FB_DEPTH = MUL_LAT / INIT_INT;
    // width of the counter for samples inside the multiplier
    localparam int FLIGHT_W = $clog2(MUL_LAT + 1);
endpackage

// File: rtl/mac_mul_pipe.sv
// Two-stage multiplier: stage one forms two partial products, and stage
// two merges them. The addend and a valid bit travel alongside.
module mac_mul_pipe #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_v,
    input  logic [W-1:0] op_x,
    input  logic [W-1:0] op_y,
    input  logic [W-1:0] add_in,
    output logic         st1_v,
    output logic         st2_v,
    output logic [W-1:0] prod,
    output logic [W-1:0] add_out
);
    localparam int HALF = W / 2;

    typedef struct packed {
        logic         v1;
        logic [W-1:0] part_lo;
        logic [W-1:0] part_hi;
        logic [W-1:0] add1;
        logic         v2;
        logic [W-1:0] prod2;
        logic [W-1:0] add2;
    } mul_st_t;

    mul_st_t st_d, st_q;
    logic [W-1:0] y_lo_ext, y_hi_ext;

    assign y_lo_ext = W'(op_y[HALF-1:0]);
    assign y_hi_ext = W'(op_y[W-1:HALF]);

    always_comb begin
        st_d    = st_q;
        st_d.v1 = in_v;
        if (in_v) begin
            st_d.part_lo = op_x * y_lo_ext;
            st_d.part_hi = op_x * y_hi_ext;
            st_d.add1    = add_in;
        end
        st_d.v2 = st_q.v1;
        if (st_q.v1) begin
            st_d.prod2 = st_q.part_lo + (st_q.part_hi << HALF);
            st_d.add2  = st_q.add1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign st1_v   = st_q.v1;
    assign st2_v   = st_q.v2;
    assign prod    = st_q.prod2;
    assign add_out = st_q.add2;
endmodule

// File: rtl/mac_fb_line.sv
// Feedback delay line of DEPTH results, with an operand selector that
// forwards the adder output when the needed result is still in flight.
module mac_fb_line #(
    parameter int W     = 32,
    parameter int DEPTH = 2,
    parameter int CW    = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  push_val,
    input  logic [CW-1:0] inflight,
    input  logic [W-1:0]  bypass_val,
    output logic [W-1:0]  fb_op
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] ent;
    } line_st_t;

    line_st_t ln_d, ln_q;
    logic [DEPTH-1:0][W-1:0] shifted;

    // entry 0 takes the newest result and each later entry takes its neighbour
    assign shifted[0] = push_val;
    for (genvar gi = 1; gi < DEPTH; gi++) begin : g_shift
        assign shifted[gi] = ln_q.ent[gi-1];
    end

    always_comb begin
        ln_d = ln_q;
        if (push) begin
            ln_d.ent = shifted;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ln_q <= '0;
        end else begin
            ln_q <= ln_d;
        end
    end

    // k samples in flight: the result needed sits k entries nearer the head,
    // or at the adder output once k reaches DEPTH
    always_comb begin
        fb_op = bypass_val;
        for (int i = 0; i < DEPTH; i++) begin
            if (inflight == CW'(i)) begin
                fb_op = ln_q.ent[DEPTH-1-i];
            end
        end
    end
endmodule

// File: rtl/mac_interleave_rec.sv
module mac_interleave_rec
    import mac_rec_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic signed [W-1:0] in_a,
    input  logic signed [W-1:0] in_b,
    output logic                out_valid,
    output logic signed [W-1:0] out_acc
);
    typedef struct packed {
        logic         ov;
        logic [W-1:0] acc;
    } out_st_t;

    out_st_t o_d, o_q;

    logic                st1_v, st2_v;
    logic [W-1:0]        prod, add_late, acc_sum, fb_op;
    logic [FLIGHT_W-1:0] inflight;

    assign acc_sum  = prod + add_late;
    assign inflight = FLIGHT_W'(st1_v) + FLIGHT_W'(st2_v);

    mac_mul_pipe #(.W(W)) u_mul (
        .clk     (clk),
        .rst     (rst),
        .in_v    (in_valid),
        .op_x    (fb_op),
        .op_y    (in_a),
        .add_in  (in_b),
        .st1_v   (st1_v),
        .st2_v   (st2_v),
        .prod    (prod),
        .add_out (add_late)
    );

    mac_fb_line #(.W(W), .DEPTH(FB_DEPTH), .CW(FLIGHT_W)) u_fb (
        .clk        (clk),
        .rst        (rst),
        .push       (st2_v),
        .push_val   (acc_sum),
        .inflight   (inflight),
        .bypass_val (acc_sum),
        .fb_op      (fb_op)
    );

    always_comb begin
        o_d    = o_q;
        o_d.ov = st2_v;
        if (st2_v) begin
            o_d.acc = acc_sum;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign out_valid = o_q.ov;
    assign out_acc   = o_q.acc;
endmodule

// File: rtl/mac_rec_checker.sv
module mac_rec_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [W-1:0] in_a,
    input logic [W-1:0] in_b,
    input logic         out_valid,
    input logic [W-1:0] out_acc
);
    logic [2:0]        v_dl;
    logic [2:0][W-1:0] a_dl, b_dl;
    logic [W-1:0]      hist_new, hist_old, exp_acc;
    logic [1:0]        run_cyc;

    always_ff @(posedge clk) begin
        if (rst) begin
            v_dl     <= '0;
            a_dl     <= '0;
            b_dl     <= '0;
            hist_new <= '0;
            hist_old <= '0;
            run_cyc  <= '0;
        end else begin
            v_dl <= {v_dl[1:0], in_valid};
            a_dl <= {a_dl[1:0], in_a};
            b_dl <= {b_dl[1:0], in_b};
            if (out_valid) begin
                hist_new <= out_acc;
                hist_old <= hist_new;
            end
            if (run_cyc != 2'd3) begin
                run_cyc <= run_cyc + 2'd1;
            end
        end
    end

    assign exp_acc = hist_old * a_dl[2] + b_dl[2];

    assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid == v_dl[2]);

    // R1 with R8: the result relates to the result two outputs back
    assert_recurrence_R1: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_acc == exp_acc);

    assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (!out_valid && run_cyc != 2'd0) |-> $stable(out_acc));

    assert_reset_clear_R7: assert property (@(posedge clk)
        ($past(rst) && !rst) |-> (!out_valid && out_acc == '0));
endmodule

bind mac_interleave_rec mac_rec_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_acc   (out_acc)
);

// File: tb/sim_mac_interleave_rec.sv
`timescale 1ns/1ps
module sim_mac_interleave_rec;
    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic signed [31:0] in_a = '0;
    logic signed [31:0] in_b = '0;
    logic               out_valid;
    logic signed [31:0] out_acc;

    int n_chk  = 0;
    int n_fail = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] m_new, m_old, last_out;
    logic [2:0]  vhist;
    int          since_rst;
    string       cur_tag, first_tag;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #10 clk = ~clk;

    mac_interleave_rec #(.W(32)) u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_a      (in_a),
        .in_b      (in_b),
        .out_valid (out_valid),
        .out_acc   (out_acc)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic monitor();
        logic [31:0] e;
        string       t;
        check(out_valid == vhist[2], "R3", 32'(out_valid), 32'(vhist[2]));
        if (out_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2", out_acc, 32'hx);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(out_acc == e, t, out_acc, e);
            end
            last_out = out_acc;
        end else begin
            check(out_acc == last_out, "R6", out_acc, last_out);
        end
    endtask

    task automatic step(input bit v, input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        monitor();
        in_valid = v;
        in_a     = a;
        in_b     = b;
        vhist    = {vhist[1:0], v};
        if (v) begin
            logic [31:0] r;
            r = m_old * a + b;
            m_old = m_new;
            m_new = r;
            exp_q.push_back(r);
            tag_q.push_back(since_rst < 2 ? first_tag : cur_tag);
            since_rst++;
        end
    endtask

    task automatic do_reset(input string ftag);
        @(negedge clk);
        rst = 1'b1;
        in_valid = 1'b0;
        exp_q.delete();
        tag_q.delete();
        m_new = '0; m_old = '0; last_out = '0;
        vhist = '0;
        since_rst = 0;
        first_tag = ftag;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R7: cleared outputs after the last reset edge
        check(!out_valid && out_acc == '0, "R7", out_acc, 32'h0);
    endtask

    task automatic drain();
        for (int i = 0; i < 5; i++) step(1'b0, 32'hDEAD_0000 + 32'(i), 32'hBEEF);
        check(exp_q.size() == 0, "R2", 32'(exp_q.size()), 32'h0);
    endtask

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        m_new = '0; m_old = '0; last_out = '0; vhist = '0; since_rst = 0;
        cur_tag = "R1"; first_tag = "R4";
        do_reset("R4");

        // R1 and R2: exhaustive small-operand sweep, one sample per cycle
        cur_tag = "R1";
        for (int ia = -4; ia <= 4; ia++)
            for (int ib = -4; ib <= 4; ib++)
                step(1'b1, 32'(ia), 32'(ib));
        drain();

        // R5: same sweep with gaps of 0..3 idle cycles carrying junk operands
        do_reset("R4");
        cur_tag = "R5";
        for (int ia = -4; ia <= 4; ia++)
            for (int ib = -4; ib <= 4; ib++) begin
                step(1'b1, 32'(ia), 32'(ib));
                for (int g = 0; g < (ia + ib + 8) % 4; g++) begin
                    lfsr = next_rand(lfsr);
                    step(1'b0, lfsr, ~lfsr);
                end
            end
        drain();

        // R8: wrap-around with extreme and pseudo-random 32-bit operands
        do_reset("R4");
        cur_tag = "R8";
        step(1'b1, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
        step(1'b1, 32'h8000_0000, 32'h8000_0000);
        step(1'b1, 32'hFFFF_FFFF, 32'h0000_0001);
        step(1'b1, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
        step(1'b1, 32'h8000_0001, 32'h7FFF_FFFF);
        for (int i = 0; i < 200; i++) begin
            lfsr = next_rand(lfsr);
            step(lfsr[3:0] != 4'h0, lfsr, {lfsr[15:0], lfsr[31:16]});
        end
        drain();

        // R9: reset while samples are in flight, then restart from zero
        cur_tag = "R1";
        for (int i = 0; i < 6; i++) step(1'b1, 32'(i + 2), 32'(i + 10));
        do_reset("R9");
        cur_tag = "R9";
        for (int i = 0; i < 8; i++) step(1'b1, 32'(3), 32'(i + 1));
        drain();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule